// File: doc/BRIEF.md
# Low-Power Mode Entry and Recovery Controller

This block decides when a small processor core and its peripherals may run. From normal operation it can take the chip into one of two low-power states. In the deep state, both the core clock enable and the peripheral clock enable drop, and so does the core-run enable. In the light state, only the core clock and the core-run enable stop, while peripherals keep their clock. All timing uses the crystal-derived clock, which keeps running while the other clocks are gated.

A wake-up from the deep state by an interrupt or a break request does not restart the core at once. A single recovery counter, held at zero for the whole time the chip is in the deep state, then counts a settling delay. The delay is long (4096 cycles) or short (32 cycles), chosen by an option bit that is captured when the deep state is entered. Only when the count ends are the clock enables raised again, together with a one-cycle pulse that tells the core it may begin stacking for the interrupt. A wake-up from the light state needs no delay: the pulse comes on the next cycle. A synchronous reset request aborts everything and returns the controller to normal operation.

Top module: `lpm_recovery_ctrl`

## Requirements
- R1: After reset the controller is running: cpu_clk_en, per_clk_en and cpu_run_en are 1 and stack_start is 0.
- R2: While running, a stop_req sampled at a clock edge clears cpu_clk_en, per_clk_en and cpu_run_en from that edge on; if stop_req and wait_req are both high, stop_req wins.
- R3: The recovery counter is held at zero for the whole stop period, so the recovery length does not depend on how long the chip stayed stopped.
- R4: With the captured option bit at 0 the enables return exactly 4096 cycles after the edge that samples the wake request; with it at 1, exactly 32 cycles.
- R5: fast_rec_sel is captured at the edge that enters stop; changes to it during stop or recovery do not change the recovery length.
- R6: In stop, only irq_req or brk_req starts recovery (and reset_req exits); wait_req and stop_req have no effect and no pulse is produced.
- R7: stack_start rises in the same cycle as the clock enables return after a recovery, never while any enable is low.
- R8: While running, wait_req (without stop_req) clears cpu_clk_en and cpu_run_en but keeps per_clk_en at 1; irq_req or brk_req in wait returns all enables at the next edge with stack_start high in that cycle.
- R9: reset_req in any state returns the controller to running at the next edge with stack_start 0, and clears the recovery counter so a later recovery is full length.
- R10: stack_start is high for exactly one cycle; irq_req and brk_req together produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock, running in every mode |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req | input | 1 | Request to enter the deep (stop) state |
| wait_req | input | 1 | Request to enter the light (wait) state |
| irq_req | input | 1 | Pending interrupt request |
| brk_req | input | 1 | Pending break request |
| reset_req | input | 1 | Synchronous reset request (pin or internal) |
| fast_rec_sel | input | 1 | 1 selects the short recovery, 0 the long one |
| cpu_clk_en | output | 1 | Gate enable for the core clock |
| per_clk_en | output | 1 | Gate enable for the peripheral clock |
| cpu_run_en | output | 1 | Core may execute |
| stack_start | output | 1 | One-cycle pulse: begin interrupt stacking |

## Verification
On every cycle the assertions check that the counter is zero whenever the controller is stopped, that the gates match the stop and wait states, that a pulse only appears with all enables high and never lasts two cycles, that a reset request always lands in the running state without a pulse, and that the count never passes its captured limit. Only the bench scenarios show the exact recovery lengths for both option values, that the option bit is captured at entry rather than followed, that a long stop dwell or an aborted recovery still yields a full-length count, and that stray requests in stop are ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LPM_RUN     = 2'd0,
    LPM_STOP    = 2'd1,
    LPM_RECOVER = 2'd2,
    LPM_WAIT    = 2'd3
  } lpm_state_e;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpm_recovery_counter.sv
module lpm_recovery_counter #(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32,
  localparam int CNT_W = $clog2(LONG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_load,
  input  logic             sel_in,
  input  logic             cnt_clr,
  input  logic             cnt_en,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LONG_TERM  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_CYCLES - 1);

  logic             sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] term;

  assign term = sel_q ? SHORT_TERM : LONG_TERM;

  // option bit: captured only on stop entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_load) begin
      sel_q <= sel_in;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_clr || cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = cnt_en && (cnt_q == term);
  assign cnt_o  = cnt_q;

  // R4: a running count never passes the captured limit
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> (cnt_q <= term));

  // R5: captured option stays fixed while counting
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !sel_load) |=> $stable(sel_q));

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake_req,
  input  logic       reset_req,
  input  logic       rec_done,
  output lpm_state_e state_o,
  output logic       sel_load,
  output logic       cnt_clr,
  output logic       cnt_en,
  output logic       pulse_o
);

  lpm_state_e state_q, state_d;
  logic       pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    if (reset_req) begin
      state_d = LPM_RUN;
    end else begin
      case (state_q)
        LPM_RUN: begin
          if (stop_req) begin
            state_d = LPM_STOP;
          end else if (wait_req) begin
            state_d = LPM_WAIT;
          end
        end
        LPM_STOP: begin
          if (wake_req) begin
            state_d = LPM_RECOVER;
          end
        end
        LPM_RECOVER: begin
          if (rec_done) begin
            state_d = LPM_RUN;
            pulse_d = 1'b1;
          end
        end
        LPM_WAIT: begin
          if (wake_req) begin
            state_d = LPM_RUN;
            pulse_d = 1'b1;
          end
        end
        default: state_d = LPM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LPM_RUN;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign sel_load = (state_q == LPM_RUN) && stop_req && !reset_req;
  assign cnt_en   = (state_q == LPM_RECOVER) && !reset_req;
  assign cnt_clr  = reset_req || (state_q != LPM_RECOVER);
  assign state_o  = state_q;
  assign pulse_o  = pulse_q;

  // R9: reset request always lands in run without a pulse
  p_reset_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (state_q == LPM_RUN) && !pulse_q);

  // R10: stacking pulse lasts one cycle
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R6: stop is only left by a wake or reset request
  p_stop_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LPM_STOP) && !wake_req && !reset_req) |=> (state_q == LPM_STOP));

endmodule

// File: rtl/lpm_clock_gate.sv
module lpm_clock_gate
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       cpu_run_en
);

  always_comb begin
    cpu_clk_en = 1'b0;
    per_clk_en = 1'b0;
    cpu_run_en = 1'b0;
    case (state_i)
      LPM_RUN: begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        cpu_run_en = 1'b1;
      end
      LPM_WAIT: begin
        per_clk_en = 1'b1;
      end
      default: begin
        cpu_clk_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lpm_recovery_ctrl.sv
module lpm_recovery_ctrl
  import lpm_pkg::*;
#(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wait_req,
  input  logic irq_req,
  input  logic brk_req,
  input  logic reset_req,
  input  logic fast_rec_sel,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic cpu_run_en,
  output logic stack_start
);

  localparam int CNT_W = $clog2(LONG_CYCLES + 1);

  logic             rst_sync_n;
  logic             wake_req;
  logic             rec_done;
  logic             sel_load;
  logic             cnt_clr;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_val;
  lpm_state_e       state;

  // break and interrupt share one wake path, so both at once give one pulse
  assign wake_req = irq_req || brk_req;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpm_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stop_req  (stop_req),
    .wait_req  (wait_req),
    .wake_req  (wake_req),
    .reset_req (reset_req),
    .rec_done  (rec_done),
    .state_o   (state),
    .sel_load  (sel_load),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .pulse_o   (stack_start)
  );

  lpm_recovery_counter #(
    .LONG_CYCLES  (LONG_CYCLES),
    .SHORT_CYCLES (SHORT_CYCLES)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel_load (sel_load),
    .sel_in   (fast_rec_sel),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .done_o   (rec_done),
    .cnt_o    (cnt_val)
  );

  lpm_clock_gate u_gate (
    .state_i    (state),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .cpu_run_en (cpu_run_en)
  );

  // R3: counter sits at zero throughout stop
  p_cnt_held_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == LPM_STOP) |-> (cnt_val == '0));

  // R2: stop gates every clock
  p_stop_gate_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == LPM_STOP || state == LPM_RECOVER) |-> (!cpu_clk_en && !per_clk_en && !cpu_run_en));

  // R8: wait keeps only the peripheral clock
  p_wait_gate_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == LPM_WAIT) |-> (per_clk_en && !cpu_clk_en && !cpu_run_en));

  // R7: pulse only with every enable high
  p_pulse_after_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stack_start |-> (cpu_clk_en && per_clk_en && cpu_run_en));

endmodule

// File: tb/lpm_recovery_ctrl_bench.sv
module lpm_recovery_ctrl_bench;

  localparam int LONG_N  = 4096;
  localparam int SHORT_N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wait_req = 1'b0, irq_req = 1'b0, brk_req = 1'b0;
  logic reset_req = 1'b0, fast_rec_sel = 1'b0;
  logic cpu_clk_en, per_clk_en, cpu_run_en, stack_start;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  lpm_recovery_ctrl u_lpm_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .irq_req(irq_req), .brk_req(brk_req), .reset_req(reset_req),
    .fast_rec_sel(fast_rec_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .cpu_run_en(cpu_run_en), .stack_start(stack_start)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act %0d cycles exp < 150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  // enables packed as {cpu_clk_en, per_clk_en, cpu_run_en}
  function automatic int gates();
    return {29'd0, cpu_clk_en, per_clk_en, cpu_run_en};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stop(input logic sel);
    fast_rec_sel = sel;
    stop_req = 1'b1;
    tick(1);
    stop_req = 1'b0;
  endtask

  // wake from stop and check exact recovery length
  task automatic wake_and_time(input string req, input int n, input logic use_brk,
                               input logic flip_sel);
    if (use_brk) brk_req = 1'b1; else irq_req = 1'b1;
    tick(1);
    irq_req = 1'b0;
    brk_req = 1'b0;
    if (flip_sel) fast_rec_sel = ~fast_rec_sel;
    tick(n - 1);
    check(req, "gates still off on last recovery cycle", gates(), 0);
    check(req, "no pulse during recovery", int'(stack_start), 0);
    tick(1);
    check(req, "gates back after recovery", gates(), 7);
    check("R7", "pulse with gates", int'(stack_start), 1);
    tick(1);
    check("R10", "pulse one cycle", int'(stack_start), 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R1", "gates after reset", gates(), 7);
    check("R1", "no pulse after reset", int'(stack_start), 0);
  endtask

  task automatic t_stop_entry();
    stop_req = 1'b1;
    wait_req = 1'b1;
    tick(1);
    stop_req = 1'b0;
    wait_req = 1'b0;
    check("R2", "stop beats wait, all gates off", gates(), 0);
    tick(5);
    check("R2", "gates stay off in stop", gates(), 0);
  endtask

  task automatic t_long_recovery();
    wake_and_time("R4", LONG_N, 1'b0, 1'b0);
  endtask

  task automatic t_short_after_dwell();
    enter_stop(1'b1);
    tick(300);
    wake_and_time("R3", SHORT_N, 1'b0, 1'b0);
  endtask

  task automatic t_sel_captured();
    enter_stop(1'b1);
    fast_rec_sel = 1'b0;
    tick(10);
    wake_and_time("R5", SHORT_N, 1'b1, 1'b1);
    enter_stop(1'b0);
    fast_rec_sel = 1'b1;
    wake_and_time("R5", LONG_N, 1'b0, 1'b0);
  endtask

  task automatic t_stop_ignores();
    enter_stop(1'b1);
    wait_req = 1'b1;
    stop_req = 1'b1;
    tick(20);
    check("R6", "wait/stop ignored in stop", gates(), 0);
    check("R6", "no pulse from ignored requests", int'(stack_start), 0);
    wait_req = 1'b0;
    stop_req = 1'b0;
    wake_and_time("R6", SHORT_N, 1'b1, 1'b0);
  endtask

  task automatic t_wait_mode();
    wait_req = 1'b1;
    tick(1);
    wait_req = 1'b0;
    check("R8", "wait keeps peripheral clock only", gates(), 2);
    tick(10);
    check("R8", "still in wait", gates(), 2);
    irq_req = 1'b1;
    brk_req = 1'b1;
    tick(1);
    irq_req = 1'b0;
    brk_req = 1'b0;
    check("R8", "wake from wait next cycle", gates(), 7);
    check("R8", "pulse at wait exit", int'(stack_start), 1);
    tick(1);
    check("R10", "single pulse for irq+brk", int'(stack_start), 0);
  endtask

  task automatic t_reset_abort();
    enter_stop(1'b1);
    irq_req = 1'b1;
    tick(1);
    irq_req = 1'b0;
    tick(20);
    reset_req = 1'b1;
    tick(1);
    reset_req = 1'b0;
    check("R9", "reset aborts recovery", gates(), 7);
    check("R9", "no pulse on reset exit", int'(stack_start), 0);
    tick(1);
    check("R9", "no late pulse", int'(stack_start), 0);
    enter_stop(1'b1);
    wake_and_time("R9", SHORT_N, 1'b0, 1'b0);
    wait_req = 1'b1;
    tick(1);
    wait_req = 1'b0;
    reset_req = 1'b1;
    tick(1);
    reset_req = 1'b0;
    check("R9", "reset leaves wait", gates(), 7);
    check("R9", "no pulse leaving wait by reset", int'(stack_start), 0);
  endtask

  initial begin
    t_reset_state();
    t_stop_entry();
    t_long_recovery();
    t_short_after_dwell();
    t_sel_captured();
    t_stop_ignores();
    t_wait_mode();
    t_reset_abort();
    tick(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule